// File: doc/BRIEF.md
# Serial-Programmed Synchronous Register Loader

This block is the control port of a frequency synthesizer. A host writes control words over three wires: serial data, a shift clock and an active-low enable. Each word carries a two-bit address in its last two bits. The address sends the payload to one of three register groups: the status group, the reference-divider ratio, or the main/swallow divider ratios. Each group keeps a shadow copy and an active copy, and only the active copy drives the divider logic.

In asynchronous mode a word takes effect as soon as the enable line returns high. In synchronous mode, reference and divider words go only to their shadow copies. Writing a main/swallow word arms a commit sequence, driven by terminal-count strobes that the dividers return to this block:
- The main/swallow ratios move to the active copy at the next main terminal count.
- The reference ratio moves at the next reference terminal count.
- The status fields move one full main-divider cycle later, so that settings tied to those fields change together with the new ratios.

The mode bits (single/dual modulus and synchronous acquisition) always apply at once. They must therefore be written before the divider words. All serial pins are sampled on the system clock. The shift clock must therefore be several times slower than `clk`.

Top module: `serial_sync_loader`

## Requirements
- R1: Bits shift in on rising edges of `ser_clk` only while `ser_en_n` is low, with the first bit sent landing in the MSB. Shift clocks seen while `ser_en_n` is high have no effect on the word that is later latched.
- R2: A word is latched when `ser_en_n` rises. The address is word bits [1:0], with codes 0 = status, 1 = reference ratio, 2 = main/swallow ratios and 3 = discarded. The payload is word bits [WORD_W-1:2].
- R3: Payload layout by group:
  - Status: payload bit 0 is dual mode, bit 1 is synchronous mode, and bits [STAT_W+1:2] are the remaining status fields.
  - Reference: the ratio is payload [REF_W-1:0].
  - Main/swallow: the swallow ratio is payload [SWAL_W-1:0] and the main ratio is the next MAIN_W bits.
- R4: Every status word updates `dual_mode` and `sync_mode` at once, whatever the current mode.
- R5: In asynchronous mode, a latched word's fields reach the active outputs by the second rising `clk` edge after `ser_en_n` rises.
- R6: In synchronous mode, status fields, reference and main/swallow words change only shadow copies. The active outputs keep their values until a commit.
- R7: A main/swallow word written in synchronous mode arms a commit. The next `main_tc` pulse copies the main/swallow shadow to the active outputs.
- R8: After arming, the next `ref_tc` pulse copies the reference shadow to `ref_ratio`.
- R9: The status fields commit on the `main_tc` pulse after the one that committed the main/swallow ratios. They do not change on the first one.
- R10: `commit_pending` is high from arming until all three commits are done. Terminal-count pulses with nothing pending leave every output unchanged.
- R11: A rewrite of a shadow before its commit replaces it, and the commit delivers the latest value.
- R12: After reset, all outputs are zero: single mode, asynchronous mode, and no commit pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock |
| ser_en_n | input | 1 | Active-low word enable |
| ref_tc | input | 1 | One-cycle reference-divider terminal-count strobe |
| main_tc | input | 1 | One-cycle main-divider terminal-count strobe |
| dual_mode | output | 1 | Active dual-modulus select |
| sync_mode | output | 1 | Active synchronous-acquisition select |
| stat_fields | output | STAT_W | Active remaining status fields |
| ref_ratio | output | REF_W | Active reference-divider ratio |
| main_ratio | output | MAIN_W | Active main-divider ratio |
| swal_ratio | output | SWAL_W | Active swallow-counter ratio |
| commit_pending | output | 1 | Synchronous commit sequence in progress |

## Verification
The bench builds the block with REF_W=8, MAIN_W=6, SWAL_W=3 and STAT_W=4, which gives an 11-bit word. Words this short keep each serial frame to a few dozen cycles. They also leave room to show that stray shift clocks with enable high would have pushed a different address into the word. The narrow fields make every field position visible in distinct small values. The two-stage status commit, the reference commit on its own strobe, and rewrites before a commit can all be exercised many times within a short run.

// File: rtl/slr_pkg.sv
// Package: shared address codes for the serial register loader.
// Assumes the address always occupies the two least significant word bits.
package slr_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_STATUS = 2'd0,
        ADDR_REF    = 2'd1,
        ADDR_DIV    = 2'd2,
        ADDR_NONE   = 2'd3
    } slr_addr_e;
endpackage

// File: rtl/slr_shift_in.sv
// Module: serial front end. Samples the three serial pins on clk, shifts
// data MSB-first on shift-clock rising edges while enable is low, and pulses
// word_valid for one cycle when enable rises.
// Assumes ser_clk is at least four clk periods per phase.
module slr_shift_in #(
    parameter int WORD_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_en_n,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    logic data_q;
    logic sclk_q, sclk_qq;
    logic en_q, en_qq;
    logic shift_now;
    logic [WORD_W-1:0] sr_q;

    // Sample the pins and keep one older copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= 1'b0;
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            en_q    <= 1'b1;
            en_qq   <= 1'b1;
        end else begin
            data_q  <= ser_data;
            sclk_q  <= ser_clk;
            sclk_qq <= sclk_q;
            en_q    <= ser_en_n;
            en_qq   <= en_q;
        end
    end

    assign shift_now = sclk_q && !sclk_qq && !en_q;

    // Shift one bit in at each enabled shift-clock rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (shift_now)
            sr_q <= {sr_q[WORD_W-2:0], data_q};
    end

    assign word_valid = en_q && !en_qq;
    assign word       = sr_q;

    a_r1_hold_while_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(sr_q));
    a_r1_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        shift_now |=> (sr_q[0] == $past(data_q)) && (sr_q[WORD_W-1:1] == $past(sr_q[WORD_W-2:0])));
endmodule

// File: rtl/slr_group_reg.sv
// Module: one shadow/active register pair. A shadow write stores din; a
// direct write also loads the active copy; a commit copies the shadow
// (value before this cycle's write) into the active copy. Direct wins.
module slr_group_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shadow_we,
    input  logic         direct_we,
    input  logic         commit,
    input  logic [W-1:0] din,
    output logic [W-1:0] active
);
    logic [W-1:0] shadow_q;

    // Hold the most recent write for a later commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (shadow_we)
            shadow_q <= din;
    end

    // Update the value the divider logic sees.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= '0;
        else if (direct_we)
            active <= din;
        else if (commit)
            active <= shadow_q;
    end

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_we && !commit) |=> $stable(active));
    a_r11_commit_latest: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !direct_we) |=> (active == $past(shadow_q)));
endmodule

// File: rtl/slr_commit_ctrl.sv
// Module: decodes latched words into group write strobes, holds the mode
// bits, and sequences synchronous commits from terminal-count strobes.
// Assumes ref_tc and main_tc are single-cycle pulses synchronous to clk.
module slr_commit_ctrl
    import slr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      word_valid,
    input  slr_addr_e addr,
    input  logic      new_dual,
    input  logic      new_sync,
    input  logic      ref_tc,
    input  logic      main_tc,
    output logic      dual_mode,
    output logic      sync_mode,
    output logic      stat_we,
    output logic      stat_direct,
    output logic      stat_commit,
    output logic      ref_we,
    output logic      ref_direct,
    output logic      ref_commit,
    output logic      div_we,
    output logic      div_direct,
    output logic      div_commit,
    output logic      pending
);
    logic main_pend_q, ref_pend_q, stat_arm_q, stat_wait_q;
    logic arm;

    // Address decode into per-group strobes.
    always_comb begin
        stat_we = word_valid && (addr == ADDR_STATUS);
        ref_we  = word_valid && (addr == ADDR_REF);
        div_we  = word_valid && (addr == ADDR_DIV);
    end

    assign stat_direct = stat_we && !new_sync;
    assign ref_direct  = ref_we && !sync_mode;
    assign div_direct  = div_we && !sync_mode;
    assign arm         = div_we && sync_mode;

    assign div_commit  = main_tc && main_pend_q;
    assign ref_commit  = ref_tc && ref_pend_q;
    assign stat_commit = main_tc && stat_wait_q;

    // Mode bits apply immediately on any status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dual_mode <= 1'b0;
            sync_mode <= 1'b0;
        end else if (stat_we) begin
            dual_mode <= new_dual;
            sync_mode <= new_sync;
        end
    end

    // Pending flags: set on arm, cleared by the matching commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_pend_q <= 1'b0;
            ref_pend_q  <= 1'b0;
            stat_arm_q  <= 1'b0;
            stat_wait_q <= 1'b0;
        end else begin
            main_pend_q <= arm || (main_pend_q && !main_tc);
            ref_pend_q  <= arm || (ref_pend_q && !ref_tc);
            stat_arm_q  <= arm || (stat_arm_q && !div_commit);
            if (div_commit)
                stat_wait_q <= stat_arm_q;
            else if (stat_commit)
                stat_wait_q <= 1'b0;
        end
    end

    assign pending = main_pend_q || ref_pend_q || stat_arm_q || stat_wait_q;

    a_r4_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we |=> (sync_mode == $past(new_sync)) && (dual_mode == $past(new_dual)));
    a_r7_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (div_commit && !arm) |=> !main_pend_q);
    a_r9_status_waits: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_wait_q) |-> $past(div_commit));
    a_r10_arm_pending: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> pending);
    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_we, ref_we, div_we}));
endmodule

// File: rtl/serial_sync_loader.sv
// Module: top of the serial register loader. Joins the serial front end,
// the commit controller and three shadow/active groups (status fields,
// reference ratio, main/swallow ratios).
// Assumes words are WORD_W bits, address in the two LSBs.
module serial_sync_loader
    import slr_pkg::*;
#(
    parameter int REF_W  = 16,
    parameter int MAIN_W = 14,
    parameter int SWAL_W = 7,
    parameter int STAT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_en_n,
    input  logic              ref_tc,
    input  logic              main_tc,
    output logic              dual_mode,
    output logic              sync_mode,
    output logic [STAT_W-1:0] stat_fields,
    output logic [REF_W-1:0]  ref_ratio,
    output logic [MAIN_W-1:0] main_ratio,
    output logic [SWAL_W-1:0] swal_ratio,
    output logic              commit_pending
);
    localparam int DIV_W  = MAIN_W + SWAL_W;
    localparam int STS_W  = STAT_W + 2;
    localparam int MAX_A  = (DIV_W > REF_W) ? DIV_W : REF_W;
    localparam int PAY_W  = (STS_W > MAX_A) ? STS_W : MAX_A;
    localparam int WORD_W = PAY_W + ADDR_W;

    logic              word_valid;
    logic [WORD_W-1:0] word;
    logic [PAY_W-1:0]  payload;
    slr_addr_e         addr;
    logic stat_we, stat_direct, stat_commit;
    logic ref_we, ref_direct, ref_commit;
    logic div_we, div_direct, div_commit;

    assign payload = word[WORD_W-1:ADDR_W];
    assign addr    = slr_addr_e'(word[ADDR_W-1:0]);

    slr_shift_in #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_data   (ser_data),
        .ser_clk    (ser_clk),
        .ser_en_n   (ser_en_n),
        .word_valid (word_valid),
        .word       (word)
    );

    slr_commit_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_valid  (word_valid),
        .addr        (addr),
        .new_dual    (payload[0]),
        .new_sync    (payload[1]),
        .ref_tc      (ref_tc),
        .main_tc     (main_tc),
        .dual_mode   (dual_mode),
        .sync_mode   (sync_mode),
        .stat_we     (stat_we),
        .stat_direct (stat_direct),
        .stat_commit (stat_commit),
        .ref_we      (ref_we),
        .ref_direct  (ref_direct),
        .ref_commit  (ref_commit),
        .div_we      (div_we),
        .div_direct  (div_direct),
        .div_commit  (div_commit),
        .pending     (commit_pending)
    );

    slr_group_reg #(.W(STAT_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .shadow_we (stat_we),
        .direct_we (stat_direct),
        .commit    (stat_commit),
        .din       (payload[STAT_W+1:2]),
        .active    (stat_fields)
    );

    slr_group_reg #(.W(REF_W)) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .shadow_we (ref_we),
        .direct_we (ref_direct),
        .commit    (ref_commit),
        .din       (payload[REF_W-1:0]),
        .active    (ref_ratio)
    );

    slr_group_reg #(.W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .shadow_we (div_we),
        .direct_we (div_direct),
        .commit    (div_commit),
        .din       (payload[DIV_W-1:0]),
        .active    ({main_ratio, swal_ratio})
    );

    a_r5_async_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_we && !sync_mode) |=> (ref_ratio == $past(payload[REF_W-1:0])));
    a_r6_sync_ref_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_we && sync_mode && !ref_commit) |=> $stable(ref_ratio));
endmodule

// File: tb/serial_sync_loader_tb.sv
// Bench: drives serial words and terminal strobes, keeps a behavioural
// reference model updated on every clock and compares all outputs each cycle,
// plus directed checks against values worked out from the requirements.
module serial_sync_loader_tb;
    localparam int REF_W  = 8;
    localparam int MAIN_W = 6;
    localparam int SWAL_W = 3;
    localparam int STAT_W = 4;
    localparam int WORD_W = 11;
    localparam int WMASK  = (1 << WORD_W) - 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_en_n = 1'b1;
    logic ref_tc = 1'b0, main_tc = 1'b0;
    logic dual_mode, sync_mode, commit_pending;
    logic [STAT_W-1:0] stat_fields;
    logic [REF_W-1:0]  ref_ratio;
    logic [MAIN_W-1:0] main_ratio;
    logic [SWAL_W-1:0] swal_ratio;

    serial_sync_loader #(.REF_W(REF_W), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .STAT_W(STAT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
        .ref_tc(ref_tc), .main_tc(main_tc), .dual_mode(dual_mode), .sync_mode(sync_mode),
        .stat_fields(stat_fields), .ref_ratio(ref_ratio), .main_ratio(main_ratio),
        .swal_ratio(swal_ratio), .commit_pending(commit_pending)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Reference model state.
    bit m_d1, m_c1, m_c2, m_e1 = 1'b1, m_e2 = 1'b1;
    int m_word, m_dual, m_sync, m_st_sh, m_st, m_ref_sh, m_ref, m_div_sh, m_div;
    bit p_main, p_ref, p_sarm, p_swait;

    always @(posedge clk) begin
        bit latch, sh, c_main, c_ref, c_stat, arm;
        int addr, pay;
        if (!rst_n) begin
            m_d1 = 0; m_c1 = 0; m_c2 = 0; m_e1 = 1; m_e2 = 1; m_word = 0;
            m_dual = 0; m_sync = 0; m_st_sh = 0; m_st = 0; m_ref_sh = 0; m_ref = 0;
            m_div_sh = 0; m_div = 0; p_main = 0; p_ref = 0; p_sarm = 0; p_swait = 0;
        end else begin
            latch  = m_e1 && !m_e2;
            sh     = m_c1 && !m_c2 && !m_e1;
            c_main = main_tc && p_main;
            c_ref  = ref_tc && p_ref;
            c_stat = main_tc && p_swait;
            if (c_main) m_div = m_div_sh;
            if (c_ref)  m_ref = m_ref_sh;
            if (c_stat) m_st  = m_st_sh;
            if (c_main)      p_swait = p_sarm;
            else if (c_stat) p_swait = 0;
            p_sarm = p_sarm && !c_main;
            p_main = p_main && !main_tc;
            p_ref  = p_ref && !ref_tc;
            arm = 0;
            if (latch) begin
                addr = m_word & 3;
                pay  = m_word >> 2;
                if (addr == 0) begin
                    m_dual  = pay & 1;
                    m_sync  = (pay >> 1) & 1;
                    m_st_sh = (pay >> 2) & ((1 << STAT_W) - 1);
                    if (m_sync == 0) m_st = m_st_sh;
                end else if (addr == 1) begin
                    m_ref_sh = pay & ((1 << REF_W) - 1);
                    if (m_sync == 0) m_ref = m_ref_sh;
                end else if (addr == 2) begin
                    m_div_sh = pay;
                    if (m_sync == 0) m_div = m_div_sh;
                    else arm = 1;
                end
            end
            if (arm) begin p_main = 1; p_ref = 1; p_sarm = 1; end
            if (sh) m_word = ((m_word << 1) | int'(m_d1)) & WMASK;
            m_c2 = m_c1; m_c1 = ser_clk;
            m_e2 = m_e1; m_e1 = ser_en_n;
            m_d1 = ser_data;
        end
    end

    // Compare every output with the model on each cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 model mode", {30'd0, dual_mode, sync_mode}, (m_dual << 1) | m_sync);
            chk("R9 model stat_fields", int'(stat_fields), m_st);
            chk("R8 model ref_ratio", int'(ref_ratio), m_ref);
            chk("R7 model main/swal", int'({main_ratio, swal_ratio}), m_div);
            chk("R10 model pending", int'(commit_pending), int'(p_main || p_ref || p_sarm || p_swait));
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input int addr, input int pay);
        int w;
        w = (pay << 2) | addr;
        ser_en_n = 1'b0;
        wait_cyc(2);
        for (int i = WORD_W - 1; i >= 0; i--) begin
            ser_data = ((w >> i) & 1) != 0;
            wait_cyc(2);
            ser_clk = 1'b1;
            wait_cyc(2);
            ser_clk = 1'b0;
        end
        wait_cyc(2);
        ser_en_n = 1'b1;
        wait_cyc(6);
    endtask

    task automatic pulse_tc(input bit r, input bit m);
        @(negedge clk);
        ref_tc = r; main_tc = m;
        @(negedge clk);
        ref_tc = 1'b0; main_tc = 1'b0;
        wait_cyc(2);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        // R12: reset state
        chk("R12 ref", int'(ref_ratio), 0);
        chk("R12 main", int'(main_ratio), 0);
        chk("R12 mode/pending", int'({dual_mode, sync_mode, commit_pending}), 0);
        // R5 R3 R2: asynchronous writes, MSB-first fields
        send_word(1, 165);
        chk("R5 async ref", int'(ref_ratio), 165);
        send_word(2, (45 << 3) | 5);
        chk("R3 main field", int'(main_ratio), 45);
        chk("R3 swal field", int'(swal_ratio), 5);
        // R2: address 3 discarded
        send_word(3, 511);
        chk("R2 discard ref", int'(ref_ratio), 165);
        chk("R2 discard main", int'(main_ratio), 45);
        chk("R2 discard stat", int'(stat_fields), 0);
        // R1: clocks with enable high must not shift (would yield ref 253)
        for (int i = 0; i < 4; i++) begin
            ser_data = (i % 2) != 0;
            wait_cyc(2); ser_clk = 1'b1; wait_cyc(2); ser_clk = 1'b0;
        end
        wait_cyc(2); ser_en_n = 1'b0; wait_cyc(4); ser_en_n = 1'b1; wait_cyc(6);
        chk("R1 ignored shift", int'(ref_ratio), 165);
        // R4: asynchronous status word
        send_word(0, (10 << 2) | 1);
        chk("R4 dual", int'(dual_mode), 1);
        chk("R5 async stat", int'(stat_fields), 10);
        // R4 R6: switch to synchronous; fields held
        send_word(0, (3 << 2) | 3);
        chk("R4 sync now", int'(sync_mode), 1);
        chk("R6 stat held", int'(stat_fields), 10);
        send_word(1, 60);
        chk("R6 ref held", int'(ref_ratio), 165);
        send_word(2, (17 << 3) | 2);
        chk("R6 main held", int'(main_ratio), 45);
        chk("R10 armed", int'(commit_pending), 1);
        // R8: reference commit on its own strobe
        pulse_tc(1'b1, 1'b0);
        chk("R8 ref commit", int'(ref_ratio), 60);
        chk("R7 main waits", int'(main_ratio), 45);
        // R7 R9: main commit, status one cycle later
        pulse_tc(1'b0, 1'b1);
        chk("R7 main commit", int'(main_ratio), 17);
        chk("R7 swal commit", int'(swal_ratio), 2);
        chk("R9 stat not yet", int'(stat_fields), 10);
        chk("R10 still pending", int'(commit_pending), 1);
        pulse_tc(1'b0, 1'b1);
        chk("R9 stat commit", int'(stat_fields), 3);
        chk("R10 cleared", int'(commit_pending), 0);
        // R10: strobes with nothing pending
        pulse_tc(1'b1, 1'b1);
        chk("R10 idle ref", int'(ref_ratio), 60);
        chk("R10 idle main", int'(main_ratio), 17);
        // R11: rewrite before commit
        send_word(2, (7 << 3) | 1);
        send_word(2, (34 << 3) | 4);
        pulse_tc(1'b0, 1'b1);
        chk("R11 latest main", int'(main_ratio), 34);
        chk("R11 latest swal", int'(swal_ratio), 4);
        wait_cyc(4);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule